// File: doc/BRIEF.md
# Registered Memory Module Power Sequencer

This controller-side sequencer brings a registered DDR memory module out of power-up and, later, parks it in self-refresh. From reset it holds the module reset low with clock enable low and a quiet command on the bus. It waits for a clock-good indication before it starts timing the module PLL lock interval and the DRAM clock-stable interval. It then releases the module reset with the command pins unchanged and waits out the register activation window. Only after that does it hand off to a separate memory initializer through a start pulse and a done input.

When the module is idle, a self-refresh request makes it issue the self-refresh entry command for one cycle. It then waits one more cycle, because the module's register delays the command by a clock, and only then pulls the module reset low. One cycle after that it optionally stops the module clocks. When the request is withdrawn, the module clocks come back and the whole power-up path runs again.

All intervals are counted in controller clock cycles. The counts come from parameters for clock frequency in MHz, PLL lock time, clock-stable time and activation cycles.

Top module: `rdimm_pwr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it: `reset_n`=0, `cke`=0, `clk_en`=1, `init_start`=0, `busy`=1, and {cs_n,ras_n,cas_n,we_n}=4'b1111 (quiet value with the default QUIET_ALL_LOW=0; 4'b0000 when it is 1).
- R2: While `clk_good` stays low, no interval is timed and `reset_n` stays low.
- R3: If the first rising edge that samples `clk_good` high is E0, then `reset_n` goes high exactly PLL_CYC+STAB_CYC edges after E0, where PLL_CYC=CLK_MHZ*PLL_US and STAB_CYC=CLK_MHZ*STAB_US.
- R4: `cke` is low whenever `reset_n` is low and throughout the activation window. The command pins hold the quiet value before, during and after the `reset_n` release.
- R5: `init_start` is high for exactly one cycle, ACT_CYC edges after `reset_n` rises.
- R6: `cke` goes high together with `init_start` and stays high while waiting for `init_done` and in idle.
- R7: `busy` is low only in idle. Idle is reached on the edge that samples `init_done` high after `init_start`, and `init_done` has no effect at any other time.
- R8: A `sr_req` sampled in idle produces, on the next cycle, the entry command {cs_n,ras_n,cas_n,we_n}=4'b0001 with `cke`=0 for one cycle. `reset_n` stays high for one more cycle and then falls. `clk_en` falls one cycle after `reset_n` when SR_CLK_GATE=1.
- R9: `sr_req` has no effect outside idle and self-refresh.
- R10: When `sr_req` is sampled low in self-refresh, `clk_en` returns high and the power-up path restarts, waiting one cycle for `clk_good` before timing again.
- R11: If `clk_good` falls during the PLL or clock-stable interval, timing restarts from the beginning once `clk_good` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| clk_good | input | 1 | Module input clock is at a usable frequency |
| sr_req | input | 1 | Request to enter (high) or leave (low) self-refresh |
| init_done | input | 1 | Memory initializer has finished |
| reset_n | output | 1 | Module register reset, active low |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| clk_en | output | 1 | Enable for the clocks driven to the module |
| init_start | output | 1 | One-cycle pulse that starts the memory initializer |
| busy | output | 1 | High except in idle |

## Verification
The assertions check the relationships that must hold on every cycle: clock enable is low while the module reset is low, the start pulse lasts one cycle, idle implies reset released and clock enable high, command pins are stable across the reset release, and the reset drop and clock gate follow the entry command in order. The exact interval lengths, the restart after losing the clock, and the cases where `init_done` or `sr_req` arrive at the wrong time can only be shown by the bench's scenarios. These depend on counting cycles from a chosen stimulus.

// File: rtl/rdimm_pwr_seq.sv
module rdimm_pwr_seq #(
  parameter int CLK_MHZ       = 100,
  parameter int PLL_US        = 100,
  parameter int STAB_US       = 200,
  parameter int ACT_CYC       = 16,
  parameter bit QUIET_ALL_LOW = 1'b0,
  parameter bit SR_CLK_GATE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_good,
  input  logic sr_req,
  input  logic init_done,
  output logic reset_n,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic clk_en,
  output logic init_start,
  output logic busy
);

  localparam int PLL_CYC  = CLK_MHZ * PLL_US;
  localparam int STAB_CYC = CLK_MHZ * STAB_US;
  localparam int MAX_CYC  = (PLL_CYC > STAB_CYC) ? ((PLL_CYC > ACT_CYC) ? PLL_CYC : ACT_CYC)
                                                 : ((STAB_CYC > ACT_CYC) ? STAB_CYC : ACT_CYC);
  localparam int CW       = $clog2(MAX_CYC + 1) + 1;
  localparam logic [3:0] QUIET = QUIET_ALL_LOW ? 4'b0000 : 4'b1111;
  localparam logic [3:0] SRE   = 4'b0001;

  typedef enum logic [3:0] {
    ST_WCLK, ST_PLL, ST_STAB, ST_ACT, ST_START, ST_INIT,
    ST_IDLE, ST_SRE, ST_SRHOLD, ST_SRRST, ST_SR
  } state_t;

  state_t state, nxt;
  logic [CW-1:0] cnt;

  wire pll_done  = (cnt == CW'(PLL_CYC - 1));
  wire stab_done = (cnt == CW'(STAB_CYC - 1));
  wire act_done  = (cnt == CW'(ACT_CYC - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_WCLK:   if (clk_good) nxt = ST_PLL;
      ST_PLL:    if (!clk_good) nxt = ST_WCLK; else if (pll_done) nxt = ST_STAB;
      ST_STAB:   if (!clk_good) nxt = ST_WCLK; else if (stab_done) nxt = ST_ACT;
      ST_ACT:    if (act_done) nxt = ST_START;
      ST_START:  nxt = ST_INIT;
      ST_INIT:   if (init_done) nxt = ST_IDLE;
      ST_IDLE:   if (sr_req) nxt = ST_SRE;
      ST_SRE:    nxt = ST_SRHOLD;
      ST_SRHOLD: nxt = ST_SRRST;
      ST_SRRST:  nxt = ST_SR;
      ST_SR:     if (!sr_req) nxt = ST_WCLK;
      default:   nxt = ST_WCLK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WCLK;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
    end
  end

  logic [3:0] cmd;
  assign cmd = (state == ST_SRE) ? SRE : QUIET;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  assign reset_n    = state inside {ST_ACT, ST_START, ST_INIT, ST_IDLE, ST_SRE, ST_SRHOLD};
  assign cke        = state inside {ST_START, ST_INIT, ST_IDLE};
  assign init_start = (state == ST_START);
  assign busy       = (state != ST_IDLE);
  assign clk_en     = !(SR_CLK_GATE && state == ST_SR);

  // R4: clock enable is low while the module reset is asserted
  p_cke_low_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_n |-> !cke);

  // R4: command pins do not move across the reset release
  p_cmd_stable_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> $stable({cs_n, ras_n, cas_n, we_n}) && !cke);

  // R5: the start handoff is a single-cycle pulse
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start);

  // R7: idle implies module out of reset with clock enable high
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> reset_n && cke && clk_en);

  // R8: after the entry command the reset is still high for a cycle
  p_sre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == SRE) |=> reset_n && !cke);

  // R8: reset only falls once the entry command has passed
  p_reset_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_n) |-> !cke && ($past({cs_n, ras_n, cas_n, we_n}) != SRE));

  // R8: clocks are gated only with the module in reset
  p_gate_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !reset_n && $past(!reset_n));

endmodule

// File: tb/sim_rdimm_pwr_seq.sv
module sim_rdimm_pwr_seq;
  localparam int TCLK = 10;
  localparam int PLLC = 4, STABC = 6, ACTC = 3;
  localparam int TREL = PLLC + STABC;

  logic clk = 0, rst_n = 0, clk_good = 0, sr_req = 0, init_done = 0;
  logic reset_n, cke, cs_n, ras_n, cas_n, we_n, clk_en, init_start, busy;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  rdimm_pwr_seq #(.CLK_MHZ(1), .PLL_US(PLLC), .STAB_US(STABC), .ACT_CYC(ACTC),
                  .QUIET_ALL_LOW(1'b0), .SR_CLK_GATE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_good(clk_good), .sr_req(sr_req), .init_done(init_done),
    .reset_n(reset_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .clk_en(clk_en), .init_start(init_start), .busy(busy));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int cmdv();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic t_reset();
    chk("R1", "reset_n", reset_n, 0); chk("R1", "cke", cke, 0);
    chk("R1", "clk_en", clk_en, 1);   chk("R1", "init_start", init_start, 0);
    chk("R1", "busy", busy, 1);       chk("R1", "cmd", cmdv(), 4'b1111);
    rst_n = 1; tick(1);
    chk("R1", "reset_n after release", reset_n, 0);
  endtask

  task automatic t_no_clock();
    tick(30);
    chk("R2", "reset_n without clk_good", reset_n, 0);
    chk("R2", "cke without clk_good", cke, 0);
  endtask

  task automatic t_clock_loss();
    clk_good = 1; tick(PLLC + 2);
    clk_good = 0; tick(5);
    chk("R11", "reset_n after clock loss", reset_n, 0);
  endtask

  task automatic t_powerup();
    clk_good = 1;
    tick(TREL);
    chk("R3", "reset_n one edge early", reset_n, 0);
    chk("R4", "cmd before release", cmdv(), 4'b1111);
    chk("R11", "restart timing reset_n low", reset_n, 0);
    tick(1);
    chk("R3", "reset_n at release edge", reset_n, 1);
    chk("R4", "cmd after release", cmdv(), 4'b1111);
    chk("R4", "cke in activation", cke, 0);
    init_done = 1; tick(1); init_done = 0;
    chk("R7", "init_done in activation ignored, busy", busy, 1);
    tick(ACTC - 2);
    chk("R5", "init_start early", init_start, 0);
    chk("R4", "cke end of activation", cke, 0);
    tick(1);
    chk("R5", "init_start pulse", init_start, 1);
    chk("R6", "cke with start", cke, 1);
    tick(1);
    chk("R5", "init_start after pulse", init_start, 0);
    chk("R6", "cke waiting init", cke, 1);
    sr_req = 1; tick(3); sr_req = 0;
    chk("R9", "sr_req during init, cmd", cmdv(), 4'b1111);
    chk("R9", "sr_req during init, reset_n", reset_n, 1);
    chk("R7", "busy before init_done", busy, 1);
    init_done = 1; tick(1); init_done = 0;
    chk("R7", "busy in idle", busy, 0);
    tick(3);
    chk("R9", "no self-refresh after ignored request", cmdv(), 4'b1111);
    chk("R6", "cke in idle", cke, 1);
    chk("R7", "still idle", busy, 0);
  endtask

  task automatic t_self_refresh();
    sr_req = 1; tick(1);
    chk("R8", "entry command", cmdv(), 4'b0001);
    chk("R8", "cke at entry", cke, 0);
    chk("R8", "reset_n at entry", reset_n, 1);
    tick(1);
    chk("R8", "cmd after entry", cmdv(), 4'b1111);
    chk("R8", "reset_n held one more cycle", reset_n, 1);
    tick(1);
    chk("R8", "reset_n falls", reset_n, 0);
    chk("R8", "clk_en before gate", clk_en, 1);
    tick(1);
    chk("R8", "clk_en gated", clk_en, 0);
    tick(5);
    chk("R8", "stays in self-refresh", clk_en, 0);
  endtask

  task automatic t_exit();
    sr_req = 0; tick(1);
    chk("R10", "clk_en back", clk_en, 1);
    chk("R10", "reset_n still low", reset_n, 0);
    chk("R10", "busy", busy, 1);
    tick(TREL);
    chk("R10", "reset_n before retimed release", reset_n, 0);
    tick(1);
    chk("R10", "reset_n after retimed release", reset_n, 1);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_no_clock();
    t_clock_loss();
    t_powerup();
    t_self_refresh();
    t_exit();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule